// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block sequences a multicycle load/store processor through ten control states, one clock cycle each. All instructions share a fetch step and a decode step. The controller then dispatches on the 6-bit opcode to a short path for one of five instruction classes: load word, store word, register-register (R-type), branch-if-equal and jump. The outputs depend only on the current state (Moore style). They steer an external datapath: memory, instruction register, register file, ALU and program counter.

The state register has four bits and a synchronous reset. The opcode input must come from the instruction register, so it stays stable from decode until the instruction ends. The datapath supplies the ALU zero flag. The block combines that flag with its own unconditional and conditional PC write strobes into a single program-counter enable. The current state number is brought out so that the sequence can be observed. An opcode outside the five classes ends the instruction after decode and returns to fetch.

Top module: `multicycle_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the state to 0 (fetch) at that edge. Reset takes priority over any opcode dispatch, including one in state 1.
- R2: State 0 always goes to state 1. In state 0 the outputs are: mem_rd=1, ir_wr=1, pc_wr=1, alu_src_a=0, alu_src_b=01 (constant 4), alu_op=00 (add) and pc_src=00 (live ALU result). Every other single-bit output is 0.
- R3: In state 1 the outputs are alu_src_a=0 (PC), alu_src_b=11 (sign-extended immediate shifted left by 2) and alu_op=00. All single-bit outputs are 0 and pc_src=00. State 1 dispatches as follows: opcode 100011 or 101011 goes to state 2, 000000 goes to state 6, 000100 goes to state 8, 000010 goes to state 9, and any other opcode goes to state 0.
- R4: The load opcode 100011 visits states 0,1,2,3,4,0. State 2 drives alu_src_a=1 (rs), alu_src_b=10 (sign-extended immediate) and alu_op=00. State 3 drives mem_rd=1 and iord=1. State 4 drives reg_wr=1, mem_to_reg=1 and reg_dst=0 (rt).
- R5: The store opcode 101011 visits states 0,1,2,5,0. State 5 drives mem_wr=1 and iord=1, with all other single-bit outputs 0.
- R6: The R-type opcode 000000 visits states 0,1,6,7,0. State 6 drives alu_src_a=1, alu_src_b=00 (B) and alu_op=10 (function field). State 7 drives reg_wr=1, reg_dst=1 (rd) and mem_to_reg=0.
- R7: The branch opcode 000100 visits states 0,1,8,0. State 8 drives pc_wr_cond=1, alu_src_a=1, alu_src_b=00, alu_op=01 (subtract) and pc_src=01 (ALUOut).
- R8: The jump opcode 000010 visits states 0,1,9,0. State 9 drives pc_wr=1 and pc_src=10 (jump address).
- R9: Every opcode other than the five listed visits states 0,1,0. No memory write or register write strobe is asserted on that path.
- R10: pc_wr is high only in states 0 and 9, pc_wr_cond only in state 8, and iord only in states 3 and 5. The state number never exceeds 9.
- R11: pc_en equals pc_wr OR (pc_wr_cond AND zero) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag from the datapath |
| pc_wr | output | 1 | Unconditional PC write strobe |
| pc_wr_cond | output | 1 | PC write strobe qualified by zero |
| pc_en | output | 1 | Combined program-counter enable |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write strobe |
| mem_to_reg | output | 1 | Register write data: 0 = ALUOut, 1 = memory data register |
| reg_dst | output | 1 | Register write destination: 0 = rt, 1 = rd |
| alu_src_a | output | 1 | First ALU operand: 0 = PC, 1 = rs value |
| alu_src_b | output | 2 | Second ALU operand select |
| alu_op | output | 2 | ALU operation class |
| pc_src | output | 2 | Next PC source select |
| state_o | output | 4 | Current state number |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the unconditional and the conditional PC write. Every opcode is swept twice, once with zero held low and once with zero held high in every state. pc_en is then checked against the bench's own formula in each cycle. It must follow zero only in state 8 and be high regardless of zero in states 0 and 9.

The second pair is reset and opcode dispatch. Reset is raised while the controller sits in decode with a jump opcode present. The next state is checked to be fetch, not jump completion.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int OPW = 6;
    localparam int STW = 4;
    localparam int SELW = 2;

    typedef enum logic [STW-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_MWR    = 4'd5,
        ST_EXE    = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRC    = 4'd8,
        ST_JMP    = 4'd9
    } state_e;

    localparam logic [OPW-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OPW-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OPW-1:0] OP_STORE = 6'b101011;
    localparam logic [OPW-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OPW-1:0] OP_JUMP  = 6'b000010;

    typedef struct packed {
        logic            pc_wr;
        logic            pc_wr_cond;
        logic            iord;
        logic            mem_rd;
        logic            mem_wr;
        logic            ir_wr;
        logic            reg_wr;
        logic            mem_to_reg;
        logic            reg_dst;
        logic            alu_src_a;
        logic [SELW-1:0] alu_src_b;
        logic [SELW-1:0] alu_op;
        logic [SELW-1:0] pc_src;
    } ctrl_t;

    typedef struct packed {
        state_e state;
    } seq_regs_t;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e         cur,
    input  logic [OPW-1:0] opcode,
    output state_e         nxt
);
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
                else if (opcode == OP_RTYPE)                 nxt = ST_EXE;
                else if (opcode == OP_BEQ)                   nxt = ST_BRC;
                else if (opcode == OP_JUMP)                  nxt = ST_JMP;
                else                                         nxt = ST_FETCH;
            end
            ST_ADDR: begin
                if (opcode == OP_LOAD)       nxt = ST_MRD;
                else if (opcode == OP_STORE) nxt = ST_MWR;
                else                         nxt = ST_FETCH;
            end
            ST_MRD:  nxt = ST_LDWB;
            ST_EXE:  nxt = ST_RWB;
            default: nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_src_b = 2'b01;
            end
            ST_DECODE: ctl.alu_src_b = 2'b11;
            ST_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = 2'b10;
            end
            ST_MRD: begin
                ctl.mem_rd = 1'b1;
                ctl.iord   = 1'b1;
            end
            ST_LDWB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            ST_MWR: begin
                ctl.mem_wr = 1'b1;
                ctl.iord   = 1'b1;
            end
            ST_EXE: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_RWB: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            ST_BRC: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.alu_src_a  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_src     = 2'b01;
            end
            ST_JMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/multicycle_ctrl.sv
module multicycle_ctrl
    import mcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPW-1:0]      opcode,
    input  logic                zero,
    output logic                pc_wr,
    output logic                pc_wr_cond,
    output logic                pc_en,
    output logic                iord,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                ir_wr,
    output logic                reg_wr,
    output logic                mem_to_reg,
    output logic                reg_dst,
    output logic                alu_src_a,
    output logic [SELW-1:0]     alu_src_b,
    output logic [SELW-1:0]     alu_op,
    output logic [SELW-1:0]     pc_src,
    output logic [STW-1:0]      state_o
);
    seq_regs_t regs_d, regs_q;
    state_e    nxt;
    ctrl_t     ctl;

    mcc_next_state i_next (.cur(regs_q.state), .opcode(opcode), .nxt(nxt));
    mcc_out_decode i_dec  (.cur(regs_q.state), .ctl(ctl));

    always_comb begin
        regs_d = regs_q;
        regs_d.state = rst ? ST_FETCH : nxt;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_en      = ctl.pc_wr | (ctl.pc_wr_cond & zero);
    assign iord       = ctl.iord;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign reg_wr     = ctl.reg_wr;
    assign mem_to_reg = ctl.mem_to_reg;
    assign reg_dst    = ctl.reg_dst;
    assign alu_src_a  = ctl.alu_src_a;
    assign alu_src_b  = ctl.alu_src_b;
    assign alu_op     = ctl.alu_op;
    assign pc_src     = ctl.pc_src;
    assign state_o    = regs_q.state;

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) rst |=> state_o == 4'd0);
    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1 || $past(rst));
    // R4
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd2 && opcode == OP_LOAD && !rst) |=> (state_o == 4'd3 || $past(rst)));
    // R7
    branch_done_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd8 |=> state_o == 4'd0);
    // R10
    state_range_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> state_o <= 4'd9);
    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R11
    branch_take_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && zero) |-> pc_en);
endmodule

// File: tb/test_multicycle_ctrl.sv
module test_multicycle_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic zero = 1'b0;
    logic pc_wr, pc_wr_cond, pc_en, iord, mem_rd, mem_wr, ir_wr, reg_wr;
    logic mem_to_reg, reg_dst, alu_src_a;
    logic [1:0] alu_src_b, alu_op, pc_src;
    logic [3:0] state_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    multicycle_ctrl i_multicycle_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .iord(iord),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .alu_src_a(alu_src_a),
        .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_src(pc_src), .state_o(state_o)
    );

    // order: pc_wr pc_wr_cond iord mem_rd mem_wr ir_wr reg_wr mem_to_reg reg_dst alu_src_a srcb op pcsrc
    function automatic logic [15:0] exp_ctl(input int st);
        case (st)
            0: return {10'b1001010000, 2'b01, 2'b00, 2'b00};
            1: return {10'b0000000000, 2'b11, 2'b00, 2'b00};
            2: return {10'b0000000001, 2'b10, 2'b00, 2'b00};
            3: return {10'b0011000000, 2'b00, 2'b00, 2'b00};
            4: return {10'b0000001100, 2'b00, 2'b00, 2'b00};
            5: return {10'b0010100000, 2'b00, 2'b00, 2'b00};
            6: return {10'b0000000001, 2'b00, 2'b10, 2'b00};
            7: return {10'b0000001010, 2'b00, 2'b00, 2'b00};
            8: return {10'b0100000001, 2'b00, 2'b01, 2'b01};
            9: return {10'b1000000000, 2'b00, 2'b00, 2'b10};
            default: return 16'h0;
        endcase
    endfunction

    function automatic int exp_next(input int st, input logic [5:0] op);
        case (st)
            0: return 1;
            1: begin
                if (op == 6'b100011 || op == 6'b101011) return 2;
                if (op == 6'b000000) return 6;
                if (op == 6'b000100) return 8;
                if (op == 6'b000010) return 9;
                return 0;
            end
            2: return (op == 6'b100011) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'b100011: return "R4";
            6'b101011: return "R5";
            6'b000000: return "R6";
            6'b000100: return "R7";
            6'b000010: return "R8";
            default:   return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_cycle(input int st, input string req);
        logic [15:0] got;
        logic exp_en;
        got = {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, reg_wr, mem_to_reg,
               reg_dst, alu_src_a, alu_src_b, alu_op, pc_src};
        chk({req, " state"}, 32'(state_o), 32'(st));
        chk({req, " controls"}, 32'(got), 32'(exp_ctl(st)));
        exp_en = (st == 0 || st == 9) || (st == 8 && zero);
        chk("R11 pc_en", 32'(pc_en), 32'(exp_en));
        if (st != 0 && st != 9) chk("R10 pc_wr place", 32'(pc_wr), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int st;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", 32'(state_o), 32'd0);
        rst = 1'b0;
        for (int z = 0; z < 2; z++) begin
            for (int op = 0; op < 64; op++) begin
                opcode = 6'(op);
                zero = z[0];
                st = 0;
                do begin
                    check_cycle(st, (st < 2) ? ((st == 0) ? "R2" : "R3") : req_of(opcode));
                    if (st == 4 || st == 5 || st == 7) ; else if (req_of(opcode) == "R9")
                        chk("R9 no writes", 32'({mem_wr, reg_wr}), 32'd0);
                    st = exp_next(st, opcode);
                    @(negedge clk);
                end while (st != 0);
                check_cycle(0, {req_of(opcode), " return"});
            end
        end
        // reset during decode with jump opcode
        opcode = 6'b000010;
        zero = 1'b0;
        @(negedge clk);
        chk("R1 decode reached", 32'(state_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset beats dispatch", 32'(state_o), 32'd0);
        @(negedge clk);
        chk("R1 reset hold", 32'(state_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 after reset", 32'(state_o), 32'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule